// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block supplies the address for a four-beat memory burst. When a new access is strobed, it registers the full start address. The two least significant bits of that address become the first beat of the burst. The upper bits are held unchanged for the whole burst. Each later clock edge on which the active-low advance input is low moves the low bits to the next beat. A static order select chooses how beats are visited: either an exclusive-OR (interleaved) pattern or a wrapping linear count. If advance is held high, the burst pauses and the current address is kept.

Inside, the block keeps a beat-step count that returns to zero on every load. The start beat is kept in the address register. The low address bits are formed from these two values, so a burst that has advanced four times lands exactly on its start beat again. Every pin is a plain control or data pin, sampled on the rising clock edge. The block has no stream handshake and never stalls the requester: a load is accepted on any edge.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets addr_out and beat to zero. The next load or advance starts from that state.
- R2: At a rising edge with load high, addr_out takes the value of addr_in, and beat takes addr_in[1:0]. Both outputs are visible once that edge has passed.
- R3: If load and advance (adv_n low) are both active at the same edge, the load wins. beat becomes the new start bits, and the next advance moves to the second beat of the new burst.
- R4: With mode high (interleaved), the beat after k advances since the last load is start XOR k, where k is taken modulo 4. For example, start 01 gives 01, 00, 11, 10.
- R5: With mode low (linear), the beat after k advances since the last load is (start + k) modulo 4. For example, start 10 gives 10, 11, 00, 01.
- R6: At an edge with load low and adv_n high, beat and addr_out keep their values.
- R7: After four advances from a load, in either order, beat equals the start beat again. The sequence then repeats.
- R8: While load stays low, the bits of addr_out above bit 1 keep the value captured at the last load, whatever adv_n does.
- R9: addr_out[1:0] always equals beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | New-access strobe; captures addr_in |
| addr_in | input | ADDR_W (17) | Start address of the burst |
| adv_n | input | 1 | Advance, active low; steps to the next beat |
| mode | input | 1 | Order select: 1 interleaved, 0 linear; held static while a burst runs |
| addr_out | output | ADDR_W (17) | Registered upper bits joined with the current beat |
| beat | output | 2 | Current two-bit beat index |

## Verification
The bench runs every start beat under both orders, with stalls mixed into the advances. A design with the wrong order table would fail on the odd starts, where XOR and add give different results. A pause that leaked a step would show up as a skipped beat. The bench drives more than four advances and checks that the burst returns to its start beat, which would catch a counter that saturates or fails to restart on load. It also checks a load and an advance at the same edge, which would catch a design that gives advance priority and starts on the second beat. Finally, it resets in the middle of a burst, which would catch a design that keeps a stale start beat or a stale upper address.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bag_step_counter.sv
module bag_step_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv_n,
  output logic [BEAT_W-1:0] step
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)         step <= '0;
    else if (load)   step <= '0;
    else if (!adv_n) step <= step + ONE;
  end

  // R3
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (step == '0));

  // R6
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(step));
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic              mode,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] step,
  output logic [BEAT_W-1:0] beat
);
  import burst_pkg::*;

  logic [BEAT_W-1:0] lin_beat;
  logic [BEAT_W-1:0] ilv_beat;

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_ilv
      assign ilv_beat[gi] = start[gi] ^ step[gi];
    end
  endgenerate

  assign lin_beat = start + step;

  always_comb begin
    if (order_e'(mode) == ORD_INTERLEAVE) beat = ilv_beat;
    else                                  beat = lin_beat;
  end

  // R7
  start_at_zero_chk: assert final ((step != '0) || (beat == start));
endmodule

// File: rtl/bag_addr_reg.sv
module bag_addr_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= addr_in;
  end

  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(addr_q));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adv_n,
  input  logic              mode,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BEAT_W-1:0] beat
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] step;

  bag_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk(clk), .rst(rst), .load(load), .addr_in(addr_in), .addr_q(addr_q)
  );

  bag_step_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .adv_n(adv_n), .step(step)
  );

  bag_order_map #(.BEAT_W(BEAT_W)) u_map (
    .mode(mode), .start(addr_q[BEAT_W-1:0]), .step(step), .beat(beat)
  );

  assign addr_out = {addr_q[ADDR_W-1 -: HI_W], beat};

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr_out == $past(addr_in)));

  // R6
  beat_pause_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(beat));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (addr_out == '0));
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int ADDR_W = 17;
  localparam int BEAT_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              adv_n = 1'b1;
  logic              mode = 1'b1;
  logic [ADDR_W-1:0] addr_out;
  logic [BEAT_W-1:0] beat;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // expected state, kept by the bench
  logic [ADDR_W-1:0] m_addr = '0;
  int                m_k = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_burst_addr_gen (
    .clk(clk), .rst(rst), .load(load), .addr_in(addr_in), .adv_n(adv_n),
    .mode(mode), .addr_out(addr_out), .beat(beat)
  );

  function automatic logic [1:0] exp_beat();
    logic [1:0] s;
    logic [1:0] k;
    s = m_addr[1:0];
    k = 2'(m_k % 4);
    if (mode) return s ^ k;
    else      return 2'((s + k) % 4);
  endfunction

  task automatic check(string tag);
    logic [1:0]        eb;
    logic [ADDR_W-1:0] ea;
    eb = exp_beat();
    ea = {m_addr[ADDR_W-1:2], eb};
    n_cmp++;
    if (beat !== eb || addr_out !== ea) begin
      n_bad++;
      $display("FAIL %s: beat=%b addr=%h expected beat=%b addr=%h",
               tag, beat, addr_out, eb, ea);
    end
    n_cmp++;
    if (addr_out[1:0] !== beat) begin
      n_bad++;
      $display("FAIL R9: low=%b expected %b", addr_out[1:0], beat);
    end
  endtask

  task automatic step(input bit r, input bit ld, input logic [ADDR_W-1:0] a,
                      input bit an);
    @(negedge clk);
    rst = r; load = ld; addr_in = a; adv_n = an;
    @(posedge clk);
    #1;
    if (r) begin m_addr = '0; m_k = 0; end
    else if (ld) begin m_addr = a; m_k = 0; end
    else if (!an) m_k++;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(1, 0, '0, 1);
    step(1, 0, '0, 1);
    check("R1");
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        for (int pat = 0; pat < 4; pat++) begin
          logic [ADDR_W-1:0] a;
          mode = md[0];
          a = ADDR_W'((s * 4) + (pat * 1237 + md * 911) * 16 + s);
          a[1:0] = 2'(s);
          step(0, 1, a, 1);
          check("R2");
          for (int i = 0; i < 11; i++) begin
            bit an;
            an = ((i + pat) % 3 == 2) ? 1'b1 : 1'b0;
            step(0, 0, '0, an);
            if (an) check("R6");
            else if (m_k % 4 == 0) check("R7");
            else if (md == 1) check("R4");
            else check("R5");
            check("R8");
          end
          // load and advance at the same edge
          a = a ^ ADDR_W'(32'h0_5a5a) ^ ADDR_W'((pat + 1) % 4);
          step(0, 1, a, 0);
          check("R3");
          step(0, 0, '0, 0);
          check("R3");
          if (pat == 3) begin
            step(1, 0, '0, 0);
            check("R1");
            step(0, 0, '0, 0);
            check("R1");
          end
        end
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule